// File: doc/BRIEF.md
# Multi-Subnet Classification Sequencer

This controller runs a classification across a neuron array split into several subnets, one subnet after another. For the subnet being fed, it raises that subnet's read strobe once for each feature element, so that an external store returns the element. One cycle later it raises the same subnet's load strobe, so that the subnet's neurons take the element in. When the last element of a subnet has been loaded, the controller holds that subnet's output strobe while the subnet's registered winner bus settles. In the next cycle it latches the winning distance and category from that bus.

The reads of the next subnet start directly after the last read of the previous subnet. They carry on while the previous subnet waits for its result. The schedule depends only on the parameters: the subnet count `N_SUB`, the packed per-subnet vector lengths `VEC_LENS`, and the bus register depth `NR`. The total run time is therefore fixed and does not depend on the data on the buses.

Top module: `subnet_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release until a start is accepted, every strobe, `rd_idx_o`, `ld_idx_o`, `busy_o`, `done_o` and every result field are zero.
- R2: A start is accepted on a clock edge at which `start_i` is high and `busy_o` is low. In the cycle after that edge (relative cycle 0) `re_o[0]` is high with `rd_idx_o` = 0. Subnets are read in ascending order. Subnet k is read for `L_k` consecutive cycles, and `rd_idx_o` counts 0 to `L_k`-1 over them. The reads of subnet k+1 begin in the cycle after the last read of subnet k. At most one read strobe is high in any cycle.
- R3: `le_o[k]` is high exactly one cycle after `re_o[k]` was high, and `ld_idx_o` in that cycle equals the `rd_idx_o` of the cycle before.
- R4: `oe_o[k]` is high for exactly `NR`+1 consecutive cycles. The first of these is the cycle after the load of element `L_k`-1 of subnet k. The window may overlap the reads and loads of later subnets, but never a load of subnet k itself.
- R5: In the cycle after the output window of subnet k closes, the controller samples `bus_dst_i[k*DST_W +: DST_W]` and `bus_cat_i[k*CAT_W +: CAT_W]`. From the next cycle on, these values appear in `dst_o[k*DST_W +: DST_W]` and `cat_o[k*CAT_W +: CAT_W]` and are held until the same subnet captures again.
- R6: `done_o` is a one-cycle pulse in relative cycle S+`NR`+3, where S is the sum of all `L_k`. All captured fields are valid in that cycle. `busy_o` is high from relative cycle 0 through S+`NR`+2 and is low in the done cycle, so a new start may be accepted there.
- R7: A start raised while `busy_o` is high is ignored: the strobes, the indices and the done time remain those of the run in progress.
- R8: The cycle count from an accepted start to `done_o` is the same whatever values the result buses carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a classification |
| bus_dst_i | input | N_SUB*DST_W | Winner distance of each subnet's registered bus, subnet k in field k |
| bus_cat_i | input | N_SUB*CAT_W | Winner category of each subnet's bus, subnet k in field k |
| re_o | output | N_SUB | Element read strobe per subnet |
| le_o | output | N_SUB | Neuron load strobe per subnet |
| oe_o | output | N_SUB | Output enable per subnet, held while the bus settles |
| rd_idx_o | output | LEN_W | Index of the element being read |
| ld_idx_o | output | LEN_W | Index of the element being loaded |
| dst_o | output | N_SUB*DST_W | Captured winner distance per subnet |
| cat_o | output | N_SUB*CAT_W | Captured winner category per subnet |
| busy_o | output | 1 | Classification in progress |
| done_o | output | 1 | One-cycle pulse when all results are valid |

## Verification
Every due time is counted from the edge that accepts a start. With the default lengths 4, 3 and 5 and `NR` = 2, subnet 0 is read in relative cycles 0 to 3, loaded in 1 to 4, enabled in 5 to 7 and captured in 8; its result is visible from cycle 9. The done pulse falls in cycle 17. A behavioural model in the bench derives the expected value of every strobe, index, result field and flag for each relative cycle from these window formulas. Outputs are compared at each falling edge, and inputs are driven after the comparison. This also means the bus value seen at a capture edge is the one the model records.

// File: rtl/subnet_seq_pkg.sv
package subnet_seq_pkg;
  // bit width able to hold values 0..n-1, never zero
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/subnet_seq_reader.sv
module subnet_seq_reader
  import subnet_seq_pkg::*;
#(
  parameter int unsigned N_SUB = 3,
  parameter int unsigned LEN_W = 6,
  parameter logic [N_SUB*LEN_W-1:0] VEC_LENS = {6'd5, 6'd3, 6'd4}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic [N_SUB-1:0] re_o,
  output logic [N_SUB-1:0] le_o,
  output logic [LEN_W-1:0] rd_idx_o,
  output logic [LEN_W-1:0] ld_idx_o
);
  localparam int unsigned SUB_W = cnt_bits(N_SUB);

  logic             act_q;
  logic [SUB_W-1:0] sub_q;
  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] cur_len;
  logic [N_SUB-1:0] le_q;
  logic [LEN_W-1:0] ld_idx_q;

  assign cur_len  = VEC_LENS[int'(sub_q)*LEN_W +: LEN_W];
  assign re_o     = act_q ? (N_SUB'(1) << sub_q) : '0;
  assign rd_idx_o = pos_q;
  assign le_o     = le_q;
  assign ld_idx_o = ld_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      sub_q <= '0;
      pos_q <= '0;
    end else if (go_i) begin
      act_q <= 1'b1;
      sub_q <= '0;
      pos_q <= '0;
    end else if (act_q) begin
      if (pos_q == cur_len - LEN_W'(1)) begin
        pos_q <= '0;
        if (sub_q == SUB_W'(N_SUB - 1)) begin
          act_q <= 1'b0;
          sub_q <= '0;
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end else begin
        pos_q <= pos_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q     <= '0;
      ld_idx_q <= '0;
    end else begin
      le_q     <= re_o;
      ld_idx_q <= act_q ? pos_q : '0;
    end
  end

  // R2
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(re_o));
  // R3
  load_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_o != '0) |=> (le_o == $past(re_o)));
endmodule

// File: rtl/subnet_seq_slot.sv
module subnet_seq_slot
  import subnet_seq_pkg::*;
#(
  parameter int unsigned LEN   = 4,
  parameter int unsigned NR    = 2,
  parameter int unsigned LEN_W = 6,
  parameter int unsigned DST_W = 8,
  parameter int unsigned CAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic [LEN_W-1:0] ld_idx_i,
  input  logic [DST_W-1:0] bus_dst_i,
  input  logic [CAT_W-1:0] bus_cat_i,
  output logic             oe_o,
  output logic             cap_o,
  output logic [DST_W-1:0] dst_o,
  output logic [CAT_W-1:0] cat_o
);
  localparam int unsigned CNT_W = cnt_bits(NR + 1);

  logic             last_ld;
  logic             oe_q;
  logic             cap_q;
  logic [CNT_W-1:0] wait_q;

  assign last_ld = le_i && (ld_idx_i == LEN_W'(LEN - 1));
  assign oe_o    = oe_q;
  assign cap_o   = cap_q;

  // settle window of NR+1 cycles, then a single capture cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      cap_q  <= 1'b0;
      wait_q <= '0;
    end else begin
      cap_q <= 1'b0;
      if (last_ld) begin
        oe_q   <= 1'b1;
        wait_q <= '0;
      end else if (oe_q) begin
        if (wait_q == CNT_W'(NR)) begin
          oe_q  <= 1'b0;
          cap_q <= 1'b1;
        end else begin
          wait_q <= wait_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o <= '0;
      cat_o <= '0;
    end else if (cap_q) begin
      dst_o <= bus_dst_i;
      cat_o <= bus_cat_i;
    end
  end

  // R4
  oe_no_self_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(oe_q && le_i));
  // R4
  oe_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) last_ld |=> oe_q);
  // R5
  cap_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_q |-> $past(oe_q));
endmodule

// File: rtl/subnet_seq.sv
module subnet_seq
  import subnet_seq_pkg::*;
#(
  parameter int unsigned N_SUB = 3,
  parameter int unsigned LEN_W = 6,
  parameter logic [N_SUB*LEN_W-1:0] VEC_LENS = {6'd5, 6'd3, 6'd4},
  parameter int unsigned NR    = 2,
  parameter int unsigned DST_W = 8,
  parameter int unsigned CAT_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N_SUB*DST_W-1:0] bus_dst_i,
  input  logic [N_SUB*CAT_W-1:0] bus_cat_i,
  output logic [N_SUB-1:0]       re_o,
  output logic [N_SUB-1:0]       le_o,
  output logic [N_SUB-1:0]       oe_o,
  output logic [LEN_W-1:0]       rd_idx_o,
  output logic [LEN_W-1:0]       ld_idx_o,
  output logic [N_SUB*DST_W-1:0] dst_o,
  output logic [N_SUB*CAT_W-1:0] cat_o,
  output logic                   busy_o,
  output logic                   done_o
);
  logic             go;
  logic             busy_q;
  logic             done_q;
  logic [N_SUB-1:0] cap;

  assign go     = start_i && !busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  subnet_seq_reader #(
    .N_SUB(N_SUB), .LEN_W(LEN_W), .VEC_LENS(VEC_LENS)
  ) i_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go),
    .re_o(re_o), .le_o(le_o), .rd_idx_o(rd_idx_o), .ld_idx_o(ld_idx_o)
  );

  for (genvar k = 0; k < N_SUB; k++) begin : g_slot
    subnet_seq_slot #(
      .LEN(int'(VEC_LENS[k*LEN_W +: LEN_W])), .NR(NR),
      .LEN_W(LEN_W), .DST_W(DST_W), .CAT_W(CAT_W)
    ) i_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .le_i(le_o[k]), .ld_idx_i(ld_idx_o),
      .bus_dst_i(bus_dst_i[k*DST_W +: DST_W]),
      .bus_cat_i(bus_cat_i[k*CAT_W +: CAT_W]),
      .oe_o(oe_o[k]), .cap_o(cap[k]),
      .dst_o(dst_o[k*DST_W +: DST_W]),
      .cat_o(cat_o[k*CAT_W +: CAT_W])
    );
  end

  // the last subnet finishes last, so its capture ends the run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap[N_SUB-1];
      if (go) busy_q <= 1'b1;
      else if (cap[N_SUB-1]) busy_q <= 1'b0;
    end
  end

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_q |-> !busy_q);
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !cap[N_SUB-1]) |=> busy_q);
endmodule

// File: tb/test_subnet_seq.sv
module test_subnet_seq;
  localparam int N_SUB = 3;
  localparam int LEN_W = 6;
  localparam logic [N_SUB*LEN_W-1:0] VEC_LENS = {6'd5, 6'd3, 6'd4};
  localparam int NR    = 2;
  localparam int DST_W = 8;
  localparam int CAT_W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [N_SUB*DST_W-1:0] bus_dst_i = '0;
  logic [N_SUB*CAT_W-1:0] bus_cat_i = '0;
  logic [N_SUB-1:0] re_o, le_o, oe_o;
  logic [LEN_W-1:0] rd_idx_o, ld_idx_o;
  logic [N_SUB*DST_W-1:0] dst_o;
  logic [N_SUB*CAT_W-1:0] cat_o;
  logic busy_o, done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  subnet_seq #(
    .N_SUB(N_SUB), .LEN_W(LEN_W), .VEC_LENS(VEC_LENS),
    .NR(NR), .DST_W(DST_W), .CAT_W(CAT_W)
  ) i_subnet_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .bus_dst_i(bus_dst_i), .bus_cat_i(bus_cat_i),
    .re_o(re_o), .le_o(le_o), .oe_o(oe_o),
    .rd_idx_o(rd_idx_o), .ld_idx_o(ld_idx_o),
    .dst_o(dst_o), .cat_o(cat_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails = 0;
  int len [N_SUB];
  int off [N_SUB];
  int exp_dst [N_SUB];
  int exp_cat [N_SUB];
  int done_at;
  int c = -1;        // relative cycle of the run, -1 when idle
  int bus_mode = 0;  // 0 random, 1 all ones, 2 all zeros
  int run_len;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at rel cycle %0d: actual %0h expected %0h", req, what, c, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // compare every output of the current cycle against the model
  task automatic compare();
    logic [N_SUB-1:0] e_re, e_le, e_oe;
    int e_rd, e_ld;
    e_re = '0; e_le = '0; e_oe = '0; e_rd = 0; e_ld = 0;
    for (int k = 0; k < N_SUB; k++) begin
      if (c >= 0) begin
        if (c >= off[k] && c < off[k] + len[k]) begin e_re[k] = 1'b1; e_rd = c - off[k]; end
        if (c - 1 >= off[k] && c - 1 < off[k] + len[k]) begin e_le[k] = 1'b1; e_ld = c - 1 - off[k]; end
        if (c >= off[k] + len[k] + 1 && c <= off[k] + len[k] + NR + 1) e_oe[k] = 1'b1;
      end
    end
    chk(re_o == e_re, "R2", "re_o", re_o, e_re);
    if (e_re != '0) chk(rd_idx_o == LEN_W'(e_rd), "R2", "rd_idx_o", rd_idx_o, e_rd);
    chk(le_o == e_le, "R3", "le_o", le_o, e_le);
    if (e_le != '0) chk(ld_idx_o == LEN_W'(e_ld), "R3", "ld_idx_o", ld_idx_o, e_ld);
    chk(oe_o == e_oe, "R4", "oe_o", oe_o, e_oe);
    for (int k = 0; k < N_SUB; k++) begin
      chk(dst_o[k*DST_W +: DST_W] == DST_W'(exp_dst[k]), "R5", "dst field", dst_o[k*DST_W +: DST_W], exp_dst[k]);
      chk(cat_o[k*CAT_W +: CAT_W] == CAT_W'(exp_cat[k]), "R5", "cat field", cat_o[k*CAT_W +: CAT_W], exp_cat[k]);
    end
    chk(busy_o == (c >= 0 && c < done_at), "R6", "busy_o", busy_o, (c >= 0 && c < done_at));
    chk(done_o == (c == done_at), "R6", "done_o", done_o, (c == done_at));
  endtask

  // one clock: check, drive, update the model for the coming edge
  task automatic cycle(input bit st);
    bit idle_now;
    @(negedge clk);
    compare();
    if (done_o && c == done_at) begin
      chk(run_len == done_at, "R8", "start-to-done cycles", run_len, done_at);
    end
    start_i = st;
    for (int k = 0; k < N_SUB; k++) begin
      case (bus_mode)
        0: begin
          bus_dst_i[k*DST_W +: DST_W] = DST_W'($urandom);
          bus_cat_i[k*CAT_W +: CAT_W] = CAT_W'($urandom);
        end
        1: begin
          bus_dst_i[k*DST_W +: DST_W] = '1;
          bus_cat_i[k*CAT_W +: CAT_W] = '1;
        end
        default: begin
          bus_dst_i[k*DST_W +: DST_W] = '0;
          bus_cat_i[k*CAT_W +: CAT_W] = '0;
        end
      endcase
      if (c == off[k] + len[k] + NR + 2) begin
        exp_dst[k] = int'(bus_dst_i[k*DST_W +: DST_W]);
        exp_cat[k] = int'(bus_cat_i[k*CAT_W +: CAT_W]);
      end
    end
    idle_now = !(c >= 0 && c < done_at);
    if (st && idle_now) begin c = 0; run_len = 0; end
    else if (c >= 0 && c < done_at) begin c++; run_len++; end
    else c = -1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, actual timeout expected finish");
    finish_run();
  end

  initial begin
    int acc;
    acc = 0;
    for (int k = 0; k < N_SUB; k++) begin
      len[k] = int'(VEC_LENS[k*LEN_W +: LEN_W]);
      off[k] = acc;
      acc += len[k];
      exp_dst[k] = 0;
      exp_cat[k] = 0;
    end
    done_at = acc + NR + 3;

    // R1: reset state, during and after reset
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_ni = 1'b1;
    repeat (3) cycle(1'b0);

    // first run, random bus data, R7 stray starts mid-run
    cycle(1'b1);
    repeat (3) cycle(1'b0);
    cycle(1'b1);   // R7
    repeat (6) cycle(1'b0);
    cycle(1'b1);   // R7, during overlap of reads and settle window
    while (c >= 0 && c < done_at) cycle(1'b0);
    // c now at done cycle: start back-to-back (R6), all-ones bus (R8)
    bus_mode = 1;
    cycle(1'b1);
    while (c >= 0 && c < done_at) cycle(1'b0);
    repeat (4) cycle(1'b0);

    // third run with all-zero bus data, same timing expected (R8)
    bus_mode = 2;
    cycle(1'b1);
    while (c >= 0 && c < done_at) cycle(1'b0);
    cycle(1'b0);
    // long start held high: only the idle edge starts (R7)
    bus_mode = 0;
    repeat (2 * done_at + 4) cycle(1'b1);
    start_i = 1'b0;
    while (c >= 0 && c < done_at) cycle(1'b0);
    repeat (3) cycle(1'b0);
    finish_run();
  end
endmodule